// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This block sits behind the serial front end of a small byte-wide nonvolatile memory. It gathers the data bytes of one write transaction into a 16-byte page latch. When the chip select rises exactly on a byte boundary, it runs a self-timed program cycle of fixed length. The front end first reports the start address, and then strobes each complete data byte. When chip select goes high, it signals the end of the transaction and says whether any partial byte was pending. A protection unit supplies a permit level, which the block samples at that moment.

The latch address advances through the low offset bits only, so a long burst folds back onto the start of the same page. A later byte to the same slot replaces the earlier one. A per-slot valid mask records which slots were actually received. During the program cycle the block replays only those slots to the array, in ascending offset order. It holds a busy flag for the whole cycle and pulses a done strobe when the cycle ends, which the surrounding logic uses to clear its write-enable latch. The physical program time is modelled by a clock counter of `CYCLE_CLKS` cycles.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `done` and `arr_we` are all 0.
- R2: Data bytes are latched at successive offsets starting from the low 4 bits of `start_addr`. On commit, each one is written to the array address formed by the upper 4 bits of `start_addr` and its offset.
- R3: The offset after 15 is 0 within the same page. A byte latched to an already filled slot replaces the earlier byte, and only the last value is written.
- R4: Only slots that received a byte in the transaction are written. Every other array location keeps its value.
- R5: A `txn_end` with `end_aligned`=0 discards the transaction. No busy cycle follows and no array write occurs.
- R6: A transaction with a start address but no data byte does not start a cycle.
- R7: A `txn_end` that arrives while `wr_permit`=0 discards the transaction.
- R8: A commit raises `busy` on the next clock and keeps it high for exactly `CYCLE_CLKS` cycles. While busy, `start_valid`, `byte_valid`, `txn_end` and changes on `wr_permit` have no effect: the cycle is not shortened and the written data does not change.
- R9: `done` is a one-cycle pulse in the first cycle after `busy` falls, and it occurs only then.
- R10: `arr_we` is asserted only while `busy` is high. Within one cycle the strobes go out in strictly ascending offset order, one slot per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start address of a write transaction is valid |
| start_addr | input | ADDR_W | Start address |
| byte_valid | input | 1 | A complete data byte has been received |
| byte_data | input | DATA_W | Data byte |
| txn_end | input | 1 | Chip select rise event |
| end_aligned | input | 1 | No partial byte pending at the chip select rise |
| wr_permit | input | 1 | Write permitted by the protection unit |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse at the end of the write cycle |

## Verification
The bench keeps its own copy of the array and replays every transaction into it using wrap-within-page rules. It drives bursts that start near the end of a page and bursts longer than a page. A design that carried into the next page, or kept the first of two bytes aimed at the same slot, would leave the wrong bytes in the array. Misaligned ends, missing permits and address-only transactions are each expected to produce no busy cycle and no strobe, so a design that commits on any chip select rise is caught by the busy flag. During busy cycles the bench injects new starts, bytes, an aligned end and a permit drop. A design that restarted or aborted its timer would show a busy length different from `CYCLE_CLKS`, or would write an injected byte.

// File: rtl/page_write_buffer.sv
`timescale 1ns/1ps
module page_write_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              txn_end,
  input  logic              end_aligned,
  input  logic              wr_permit,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              busy,
  output logic              done
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int TMR_W  = $clog2(CYCLE_CLKS);

  logic [DATA_W-1:0]     lat_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_W-1:0]     page_q;
  logic [OFF_W-1:0]      ptr_q;
  logic [TMR_W-1:0]      tmr_q;
  logic                  collect_q, busy_q, done_q;

  wire              tmr_last = (tmr_q == TMR_W'(CYCLE_CLKS - 1));
  wire              accept   = collect_q && !busy_q;
  wire              commit   = accept && txn_end && end_aligned && wr_permit && (|mask_q);
  wire [OFF_W-1:0]  slot     = tmr_q[OFF_W-1:0];
  wire              in_wb    = (tmr_q < TMR_W'(PAGE_BYTES));

  assign arr_we    = busy_q && in_wb && mask_q[slot];
  assign arr_addr  = {page_q, slot};
  assign arr_wdata = lat_q[slot];
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collect_q <= 1'b0;
      mask_q    <= '0;
      page_q    <= '0;
      ptr_q     <= '0;
    end else if (!busy_q) begin
      if (start_valid) begin
        collect_q <= 1'b1;
        mask_q    <= '0;
        page_q    <= start_addr[ADDR_W-1:OFF_W];
        ptr_q     <= start_addr[OFF_W-1:0];
      end else if (txn_end) begin
        collect_q <= 1'b0;
      end else if (collect_q && byte_valid) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_BYTES; i++) lat_q[i] <= '0;
    end else if (accept && byte_valid && !start_valid && !txn_end) begin
      lat_q[ptr_q] <= byte_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (tmr_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          tmr_q  <= '0;
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
      end else if (commit) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
      end
    end
  end

  assert_no_stray_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_busy_from_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txn_end && end_aligned && wr_permit));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_last) |=> busy);

  assert_page_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFF_W]));

  assert_we_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we) && $past(busy)) |-> (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));
endmodule

// File: tb/page_write_buffer_test.sv
`timescale 1ns/1ps
module page_write_buffer_test;
  localparam int CYC = 64;

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, byte_valid = 0, txn_end = 0, end_aligned = 1, wr_permit = 1;
  logic [7:0] start_addr = 0, byte_data = 0;
  logic arr_we, busy, done;
  logic [7:0] arr_addr, arr_wdata;

  page_write_buffer #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(16), .CYCLE_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .txn_end(txn_end),
    .end_aligned(end_aligned), .wr_permit(wr_permit), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] dut_mem [256];
  logic [7:0] exp_mem [256];
  int wr_cnt = 0, stray = 0, order_err = 0;
  int last_off = -1;

  always @(posedge clk) begin
    if (rst_n && arr_we) begin
      dut_mem[arr_addr] = arr_wdata;
      wr_cnt++;
      if (!busy) stray++;
      if (int'(arr_addr[3:0]) <= last_off) order_err++;
      last_off = int'(arr_addr[3:0]);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < 256; i++) if (dut_mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  task automatic txn(input logic [7:0] addr, input int n, input bit aligned,
                     input bit permit, input bit poke, input string req);
    logic [7:0] sb [16];
    bit [15:0] m = 0;
    int off, cnt, pc;
    bit commit;
    wr_cnt = 0; stray = 0; order_err = 0; last_off = -1;
    @(negedge clk); start_valid = 1; start_addr = addr;
    @(negedge clk); start_valid = 0;
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      off = (int'(addr[3:0]) + i) % 16;
      sb[off] = d; m[off] = 1'b1;
      byte_valid = 1; byte_data = d;
      @(negedge clk); byte_valid = 0;
      if ($urandom % 4 == 0) @(negedge clk);
    end
    txn_end = 1; end_aligned = aligned; wr_permit = permit;
    @(negedge clk); txn_end = 0; end_aligned = 1; wr_permit = 1;
    commit = aligned && permit && (n > 0);
    pc = 0;
    for (int s = 0; s < 16; s++) if (m[s]) begin
      pc++;
      if (commit) exp_mem[{addr[7:4], 4'(s)}] = sb[s];
    end
    if (commit) begin
      cnt = 0;
      while (busy && cnt < CYC + 10) begin
        if (poke && cnt == 2) begin
          start_valid = 1; start_addr = addr ^ 8'h30; byte_valid = 1; byte_data = 8'hEE;
          txn_end = 1; end_aligned = 1; wr_permit = 0;
        end
        if (poke && cnt == 3) begin
          start_valid = 0; byte_valid = 0; txn_end = 0; wr_permit = 1;
        end
        cnt++;
        @(negedge clk);
      end
      chk({req, " R8 busy length"}, cnt, CYC);
      chk({req, " R9 done at busy fall"}, int'(done), 1);
      @(negedge clk);
      chk({req, " R9 done one cycle"}, int'(done), 0);
      chk({req, " R4 write count"}, wr_cnt, pc);
    end else begin
      cnt = 0;
      for (int k = 0; k < CYC + 4; k++) begin
        if (busy || done) cnt++;
        @(negedge clk);
      end
      chk({req, " no cycle"}, cnt, 0);
      chk({req, " no writes"}, wr_cnt, 0);
    end
    chk({req, " R10 stray strobes"}, stray, 0);
    chk({req, " R10 order"}, order_err, 0);
    chk({req, " R2 R3 R4 array contents"}, mem_diffs(), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7781));
    for (int i = 0; i < 256; i++) begin
      dut_mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 we in reset", int'(arr_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    txn(8'h23, 1, 1, 1, 0, "R2 single byte");
    txn(8'h40, 16, 1, 1, 0, "R2 full page");
    txn(8'h7C, 8, 1, 1, 0, "R3 wrap");
    txn(8'h95, 20, 1, 1, 0, "R3 overwrite");
    txn(8'hA3, 3, 1, 1, 0, "R4 partial page");
    txn(8'h10, 3, 0, 1, 0, "R5 misaligned end");
    txn(8'h60, 0, 1, 1, 0, "R6 address only");
    txn(8'hC4, 5, 1, 0, 0, "R7 no permit");
    txn(8'hD8, 6, 1, 1, 1, "R8 inputs during busy");
    for (int r = 0; r < 12; r++) begin
      txn(8'($urandom), int'($urandom % 21), ($urandom % 5) != 0,
          ($urandom % 7) != 0, ($urandom % 3) == 0, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule